// File: doc/BRIEF.md
# DRAM Clock-Frequency-Change Sequencer

This block sits on the memory-controller side. It runs a change of the DRAM clock frequency while the device is parked in precharge power-down. A single request pulse starts the sequence. The sequencer first forces the termination control low and lets the termination turn-off delay expire with CKE still high. It then drops CKE to enter power-down and holds it low while the old clock runs for its required stable period. Next it asks the clock source to switch and waits for the clock source to acknowledge. After that it counts the stable period at the new clock and raises CKE to leave power-down. Once the exit-to-command delay has passed, it issues one mode-register command that resets the DLL. It then holds the bus at NOP for the DLL lock time before it hands the bus back.

Each timing parameter is a programmable cycle count on an input port. All of them share one down-counter. The sequence is the same for slow-exit and fast-exit power-down, so no mode input exists. Every port is a plain control or status signal. No data stream passes through the block, so there is no valid/ready back-pressure.

Top module: `freq_change_seq`

## Requirements
- R1: After reset the block is idle: `cke`=1, `cmd`=NOP (3'b111), `seq_done`=0, `clk_sw_req`=0, `cmd_allow`=1, `cmd_addr`=0.
- R2: A `seq_req` sampled while idle starts the sequence. For the next max(`t_aof`,1) cycles, `cke` stays 1, `odt` is 0 and `cmd` is NOP. Then `cke` falls.
- R3: `cke` stays 0 for max(`t_sre`,1) cycles before `clk_sw_req` rises, and it stays 0 for as long as `clk_sw_req` is high.
- R4: `odt` follows `odt_in` only while idle. It is 0 in every cycle from the one after the accepted request until the block returns to idle.
- R5: `clk_sw_req` stays high until the cycle in which `clk_sw_ack` is sampled high. A `clk_sw_ack` seen while `clk_sw_req` is low has no effect.
- R6: After the acknowledge, `cke` stays 0 for max(`t_srx`,1) more cycles and then rises.
- R7: After `cke` rises, `cmd` stays NOP for 1+max(`t_xp`,1) cycles. Then, for exactly one cycle, `cmd` is MRS (3'b000) and `cmd_addr` equals `mr_base` with bit `DLL_BIT` (default 8) set.
- R8: After the MRS cycle, `cmd` is NOP for max(`t_dllk`,1) cycles. Then `seq_done` is high for exactly one cycle, and the block is idle in the following cycle.
- R9: `cmd_allow` is 1 only while idle. A `seq_req` that arrives while the sequence runs is ignored and does not restart or lengthen it.
- R10: `cmd` is NOP in every cycle other than the single MRS cycle, and `cmd_addr` is 0 in those cycles.
- R11: A timing count of zero behaves exactly like a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_req | input | 1 | Start a frequency change (sampled while idle) |
| seq_done | output | 1 | One-cycle pulse when the sequence ends |
| cmd_allow | output | 1 | High when normal commands may be scheduled |
| odt_in | input | 1 | Termination request from the scheduler, passed through while idle |
| t_aof | input | CNT_W | Termination turn-off delay before power-down, in cycles |
| t_sre | input | CNT_W | Stable old-clock cycles after power-down entry |
| t_srx | input | CNT_W | Stable new-clock cycles before power-down exit |
| t_xp | input | CNT_W | Exit-to-command delay, in cycles |
| t_dllk | input | CNT_W | DLL lock time, in cycles |
| mr_base | input | ADDR_W | Mode-register value that the DLL-reset command carries |
| clk_sw_req | output | 1 | Request to the clock source to switch frequency |
| clk_sw_ack | input | 1 | Clock source reports that the switch is complete |
| cke | output | 1 | DRAM clock enable |
| odt | output | 1 | DRAM termination control |
| cmd | output | 3 | Command as {RAS#,CAS#,WE#}: NOP 3'b111, MRS 3'b000 |
| cmd_addr | output | ADDR_W | Address bus for the MRS command |

## Verification
The bench runs the whole sequence with four sets of timing values. One set has every count at zero, which separates the zero-means-one rule from an off-by-one in the counter. Another has a long lock time and mixed lengths, which exposes a wrong count in any single state. The acknowledge delay ranges from zero cycles to several, so a sequencer that leaves the switch state without the acknowledge, or that misses it, gets out of step with the reference. A stray acknowledge before the switch request and a second start request during the sequence test that both are ignored. `odt_in` toggles throughout, which shows that it passes through while idle and is forced low everywhere else.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PDE, S_SRE, S_FSW, S_SRX, S_PDX, S_XP, S_MRS, S_DLLK, S_DONE
  } fcs_state_e;

  localparam logic [2:0] CMD_NOP = 3'b111;
  localparam logic [2:0] CMD_MRS = 3'b000;
endpackage

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
  end

  // zero and one both end the wait after a single cycle
  assign last = (cnt <= CNT_W'(1));
endmodule

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_req,
  input  logic             clk_sw_ack,
  input  logic             tmr_last,
  input  logic [CNT_W-1:0] t_aof,
  input  logic [CNT_W-1:0] t_sre,
  input  logic [CNT_W-1:0] t_srx,
  input  logic [CNT_W-1:0] t_xp,
  input  logic [CNT_W-1:0] t_dllk,
  output fcs_state_e       state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);
  fcs_state_e nxt;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state)
      S_IDLE: if (seq_req)    begin nxt = S_PDE; tmr_load = 1'b1; tmr_val = t_aof; end
      S_PDE:  if (tmr_last)   begin nxt = S_SRE; tmr_load = 1'b1; tmr_val = t_sre; end
      S_SRE:  if (tmr_last)   nxt = S_FSW;
      S_FSW:  if (clk_sw_ack) begin nxt = S_SRX; tmr_load = 1'b1; tmr_val = t_srx; end
      S_SRX:  if (tmr_last)   nxt = S_PDX;
      S_PDX:  begin nxt = S_XP; tmr_load = 1'b1; tmr_val = t_xp; end
      S_XP:   if (tmr_last)   nxt = S_MRS;
      S_MRS:  begin nxt = S_DLLK; tmr_load = 1'b1; tmr_val = t_dllk; end
      S_DLLK: if (tmr_last)   nxt = S_DONE;
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/fcs_outdec.sv
module fcs_outdec
  import fcs_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int DLL_BIT = 8
) (
  input  fcs_state_e        state,
  input  logic              odt_in,
  input  logic [ADDR_W-1:0] mr_base,
  output logic              cke,
  output logic              odt,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              clk_sw_req,
  output logic              seq_done,
  output logic              cmd_allow
);
  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_BIT;

  logic in_pd;
  logic is_mrs;

  assign in_pd      = (state == S_SRE) || (state == S_FSW) || (state == S_SRX);
  assign is_mrs     = (state == S_MRS);
  assign cmd_allow  = (state == S_IDLE);
  assign cke        = !in_pd;
  assign odt        = cmd_allow && odt_in;
  assign cmd        = is_mrs ? CMD_MRS : CMD_NOP;
  assign cmd_addr   = is_mrs ? (mr_base | DLL_MASK) : '0;
  assign clk_sw_req = (state == S_FSW);
  assign seq_done   = (state == S_DONE);
endmodule

// File: rtl/freq_change_seq.sv
module freq_change_seq
  import fcs_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int ADDR_W  = 14,
  parameter int DLL_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_req,
  output logic              seq_done,
  output logic              cmd_allow,
  input  logic              odt_in,
  input  logic [CNT_W-1:0]  t_aof,
  input  logic [CNT_W-1:0]  t_sre,
  input  logic [CNT_W-1:0]  t_srx,
  input  logic [CNT_W-1:0]  t_xp,
  input  logic [CNT_W-1:0]  t_dllk,
  input  logic [ADDR_W-1:0] mr_base,
  output logic              clk_sw_req,
  input  logic              clk_sw_ack,
  output logic              cke,
  output logic              odt,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] cmd_addr
);
  fcs_state_e       state;
  logic             tmr_load;
  logic             tmr_last;
  logic [CNT_W-1:0] tmr_val;

  fcs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .last(tmr_last)
  );

  fcs_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .clk_sw_ack(clk_sw_ack),
    .tmr_last(tmr_last), .t_aof(t_aof), .t_sre(t_sre), .t_srx(t_srx),
    .t_xp(t_xp), .t_dllk(t_dllk), .state(state), .tmr_load(tmr_load),
    .tmr_val(tmr_val)
  );

  fcs_outdec #(.ADDR_W(ADDR_W), .DLL_BIT(DLL_BIT)) u_dec (
    .state(state), .odt_in(odt_in), .mr_base(mr_base), .cke(cke), .odt(odt),
    .cmd(cmd), .cmd_addr(cmd_addr), .clk_sw_req(clk_sw_req),
    .seq_done(seq_done), .cmd_allow(cmd_allow)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
  import fcs_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_req,
  input logic              seq_done,
  input logic              cmd_allow,
  input logic              clk_sw_req,
  input logic              clk_sw_ack,
  input logic              cke,
  input logic              odt,
  input logic [2:0]        cmd,
  input logic [ADDR_W-1:0] cmd_addr
);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_allow && seq_req |=> !cmd_allow && cke && !odt);
  p_sw_in_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw_req |-> !cke);
  p_odt_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_allow |-> !odt);
  p_sw_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw_req && !clk_sw_ack |=> clk_sw_req);
  p_sw_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sw_req && clk_sw_ack |=> !clk_sw_req && !cke);
  p_mrs_cke_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_MRS |-> cke && !cmd_allow && cmd_addr != '0);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done && cmd_allow);
  p_allow_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_allow |-> cke && cmd == CMD_NOP);
  p_mrs_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == CMD_MRS |=> cmd == CMD_NOP);
endmodule

bind freq_change_seq fcs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_done(seq_done),
  .cmd_allow(cmd_allow), .clk_sw_req(clk_sw_req), .clk_sw_ack(clk_sw_ack),
  .cke(cke), .odt(odt), .cmd(cmd), .cmd_addr(cmd_addr)
);

// File: tb/sim_freq_change_seq.sv
`timescale 1ns/1ps
module sim_freq_change_seq;
  localparam int CNT_W = 12;
  localparam int ADDR_W = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_req = 1'b0, odt_in = 1'b0, clk_sw_ack = 1'b0;
  logic [CNT_W-1:0] t_aof = '0, t_sre = '0, t_srx = '0, t_xp = '0, t_dllk = '0;
  logic [ADDR_W-1:0] mr_base = 14'h0215;
  logic seq_done, cmd_allow, clk_sw_req, cke, odt;
  logic [2:0] cmd;
  logic [ADDR_W-1:0] cmd_addr;

  int total = 0, bad = 0, cycles = 0;
  int ph = 0, rem = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  freq_change_seq u0 (
    .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_done(seq_done),
    .cmd_allow(cmd_allow), .odt_in(odt_in), .t_aof(t_aof), .t_sre(t_sre),
    .t_srx(t_srx), .t_xp(t_xp), .t_dllk(t_dllk), .mr_base(mr_base),
    .clk_sw_req(clk_sw_req), .clk_sw_ack(clk_sw_ack), .cke(cke), .odt(odt),
    .cmd(cmd), .cmd_addr(cmd_addr)
  );

  function automatic int m1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (phase %0d)", req, act, exp, ph);
    end
  endtask

  // reference: phase list 0 idle,1 odt-off,2 old-clock wait,3 switch,4 new-clock wait,
  // 5 exit,6 exit delay,7 mrs,8 lock wait,9 done
  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else case (ph)
      0: if (seq_req) begin ph = 1; rem = m1(int'(t_aof)); end
      1: if (rem <= 1) begin ph = 2; rem = m1(int'(t_sre)); end else rem--;
      2: if (rem <= 1) ph = 3; else rem--;
      3: if (clk_sw_ack) begin ph = 4; rem = m1(int'(t_srx)); end
      4: if (rem <= 1) ph = 5; else rem--;
      5: begin ph = 6; rem = m1(int'(t_xp)); end
      6: if (rem <= 1) ph = 7; else rem--;
      7: begin ph = 8; rem = m1(int'(t_dllk)); end
      8: if (rem <= 1) ph = 9; else rem--;
      default: ph = 0;
    endcase
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic e_cke, e_odt, e_sw, e_done, e_allow;
      logic [2:0] e_cmd;
      logic [ADDR_W-1:0] e_addr;
      e_cke   = !(ph == 2 || ph == 3 || ph == 4);
      e_odt   = (ph == 0) && odt_in;
      e_sw    = (ph == 3);
      e_done  = (ph == 9);
      e_allow = (ph == 0);
      e_cmd   = (ph == 7) ? 3'b000 : 3'b111;
      e_addr  = (ph == 7) ? (mr_base | 14'h0100) : '0;
      chk(cke == e_cke, "R2/R3/R6 cke", cke, e_cke);
      chk(odt == e_odt, "R4 odt", odt, e_odt);
      chk(clk_sw_req == e_sw, "R5 clk_sw_req", clk_sw_req, e_sw);
      chk(cmd == e_cmd, "R7/R10 cmd", cmd, e_cmd);
      chk(cmd_addr == e_addr, "R7/R10 cmd_addr", cmd_addr, e_addr);
      chk(seq_done == e_done, "R8 seq_done", seq_done, e_done);
      chk(cmd_allow == e_allow, "R9 cmd_allow", cmd_allow, e_allow);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 50000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one sequence; R9 stray request at cycle busy_at, R5 stray ack at cycle 1
  task automatic run_seq(int aof, int sre, int srx, int xp, int dllk, int ack_dly, int busy_at);
    int c = 0, swc = 0, tail = -1;
    t_aof = CNT_W'(aof); t_sre = CNT_W'(sre); t_srx = CNT_W'(srx);
    t_xp = CNT_W'(xp); t_dllk = CNT_W'(dllk);
    while (tail != 0) begin
      @(posedge clk); #1;
      seq_req = (c == 0) || (c == busy_at);
      odt_in  = ~odt_in;
      clk_sw_ack = (c == 1) && !clk_sw_req;
      if (clk_sw_req) begin
        if (swc == ack_dly) clk_sw_ack = 1'b1;
        swc++;
      end
      if (tail > 0) tail--;
      if (seq_done && tail < 0) tail = 3;
      c++;
    end
    seq_req = 1'b0; clk_sw_ack = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(cke == 1'b1, "R1 cke", cke, 1);
    chk(cmd == 3'b111, "R1 cmd", cmd, 3'b111);
    chk(seq_done == 1'b0, "R1 seq_done", seq_done, 0);
    chk(clk_sw_req == 1'b0, "R1 clk_sw_req", clk_sw_req, 0);
    chk(cmd_allow == 1'b1, "R1 cmd_allow", cmd_allow, 1);
    chk(cmd_addr == '0, "R1 cmd_addr", cmd_addr, 0);
    rst_n = 1'b1;
    run_seq(2, 5, 4, 3, 20, 3, 4);
    run_seq(0, 0, 0, 0, 0, 0, 2);      // R11 zero counts
    run_seq(1, 1, 1, 1, 1, 7, 12);
    run_seq(4, 10, 6, 8, 64, 1, 30);
    repeat (4) @(posedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule